// File: doc/BRIEF.md
# SPI Serial Clock Mode Generator

This block turns one internal serial clock, which always behaves like SPI Mode 3 (idle high, data launched on the falling edge and captured on the rising edge), into the clock driven onto the SPI bus in any of the four clock modes. It does not run a separate clock generator for each mode. A one-bit mask state gates the internal clock, and a final XOR applies the polarity correction.

The mask has two states. In `ST_HOLD` the bus clock is forced low. In `ST_PASS` the internal clock goes through. The transition `ARM` (HOLD to PASS) happens whenever the synchronised internal clock is low. The transition `CLEAR` (PASS to HOLD, or staying in HOLD) happens when a bus read of the received byte occurs while the phase bit is 0. The phase bit is therefore the mode select of the mask logic. The masked clock is XORed with (polarity XOR phase) and then registered.

Software use is as follows. In phase-0 operation, a dummy read of the received byte clears the mask before the peripheral select is asserted, and the received byte must be read after every transfer. In phase-1 operation, a dummy write produces the low phase that arms the mask. The internal clock passes through the `sync_stages` synchroniser before it is used. Everything runs on one system clock.

Top module: `sclk_mode_gen`

## Requirements
- R1: While reset is asserted and after it is released, the mask is in `ST_HOLD` and `bus_sclk` is 0, until the first low phase of the internal clock.
- R2: The mask is cleared only when `sel_n`, `rd_n` and `cpha` are all 0 in the same system clock cycle. `sel_n` low alone, with `rd_n` high, leaves the mask and the output unchanged.
- R3: A low phase of the internal clock arms the mask. The output stays at its idle level during that low phase and follows the internal clock from its next rising edge onward.
- R4: When a clear and an arm occur in the same cycle, the clear wins. A read strobe held across a low phase keeps the output idle after the internal clock rises.
- R5: With `cpha` = 1 the read strobe has no effect. Once armed, the internal clock is passed straight through (Mode 3 when `cpol` = 1).
- R6: In phase-0 operation the output stays high after the final rising edge of a transfer. It returns to idle low only after a read strobe.
- R7: `bus_sclk` equals the masked clock XORed with (`cpol` XOR `cpha`). It is inverted only when `cpol` and `cpha` differ, which gives Mode 2 (idle high) and Mode 1 (idle low).
- R8: `bus_sclk` is a register output and changes only at system clock edges. Its value equals the masked and corrected clock of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_sclk | input | 1 | Internal Mode 3 serial clock (idle high) |
| cpol | input | 1 | Clock polarity select |
| cpha | input | 1 | Clock phase select; also the mask mode select |
| sel_n | input | 1 | Active-low device select from the bus |
| rd_n | input | 1 | Active-low read strobe of the received byte |
| bus_sclk | output | 1 | Serial clock driven onto the SPI bus |

## Verification
The bench overrides `SYNC_STAGES` to 3 instead of the default 2. It waits a settle time derived from that value before every sample, so each check holds whatever the exact synchroniser depth is. With the deeper pipeline, the internal clock reaches the mask several cycles after the read strobe. This makes it possible to hold a strobe across a complete low phase and test the clear-over-arm priority, and to test that a lone select strobe is ignored. All four clock modes are run in sequence, each entered with the dummy access that mode needs.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_PASS = 1'b1
    } mask_st_e;
endpackage

// File: rtl/sclk_sync.sv
module sclk_sync #(
    parameter int STAGES    = 2,
    parameter bit RST_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q[0] <= RST_LEVEL;
        else        pipe_q[0] <= d_in;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) pipe_q[g] <= RST_LEVEL;
            else        pipe_q[g] <= pipe_q[g-1];
        end
    end

    assign q_out = pipe_q[STAGES-1];
endmodule

// File: rtl/sclk_mask_fsm.sv
module sclk_mask_fsm
    import sclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic s_clk,
    input  logic clr_req,
    output logic mask_on
);
    mask_st_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // transitions: CLEAR has priority over ARM
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: if (!clr_req && !s_clk) state_d = ST_PASS;
            ST_PASS: if (clr_req)            state_d = ST_HOLD;
            default:                         state_d = ST_HOLD;
        endcase
    end

    // outputs
    always_comb begin
        mask_on = 1'b0;
        unique case (state_q)
            ST_HOLD: mask_on = 1'b0;
            ST_PASS: mask_on = 1'b1;
            default: mask_on = 1'b0;
        endcase
    end
endmodule

// File: rtl/sclk_out_stage.sv
module sclk_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic s_clk,
    input  logic mask_on,
    input  logic cpol,
    input  logic cpha,
    output logic bus_sclk
);
    logic two_mode;
    logic flip;
    logic out_d;

    always_comb begin
        two_mode = s_clk & mask_on;
        flip     = cpol ^ cpha;
        out_d    = two_mode ^ flip;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bus_sclk <= 1'b0;
        else        bus_sclk <= out_d;
    end
endmodule

// File: rtl/sclk_mode_gen.sv
module sclk_mode_gen #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic int_sclk,
    input  logic cpol,
    input  logic cpha,
    input  logic sel_n,
    input  logic rd_n,
    output logic bus_sclk
);
    localparam int STG = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

    logic s_clk;
    logic clr_req;
    logic mask_on;

    assign clr_req = ~(sel_n | rd_n | cpha);

    sclk_sync #(.STAGES(STG), .RST_LEVEL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (int_sclk),
        .q_out (s_clk)
    );

    sclk_mask_fsm u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_clk   (s_clk),
        .clr_req (clr_req),
        .mask_on (mask_on)
    );

    sclk_out_stage u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_clk    (s_clk),
        .mask_on  (mask_on),
        .cpol     (cpol),
        .cpha     (cpha),
        .bus_sclk (bus_sclk)
    );
endmodule

// File: rtl/sclk_mode_gen_chk.sv
module sclk_mode_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic cpol,
    input logic cpha,
    input logic sel_n,
    input logic rd_n,
    input logic s_clk,
    input logic mask_on,
    input logic bus_sclk
);
    logic live_q;
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R1
    rst_idle_chk: assert property (@(posedge clk) !rst_n |=> (!bus_sclk && !mask_on));

    // R2
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !rd_n && !cpha) |=> !mask_on);

    // R3
    arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_clk && (sel_n || rd_n || cpha)) |=> mask_on);

    // R4
    prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_clk && !sel_n && !rd_n && !cpha) |=> !mask_on);

    // R5
    keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpha && mask_on) |=> mask_on);

    // R7
    out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |=> (bus_sclk == $past((s_clk & mask_on) ^ cpol ^ cpha)));
endmodule

bind sclk_mode_gen sclk_mode_gen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpol     (cpol),
    .cpha     (cpha),
    .sel_n    (sel_n),
    .rd_n     (rd_n),
    .s_clk    (s_clk),
    .mask_on  (mask_on),
    .bus_sclk (bus_sclk)
);

// File: tb/test_sclk_mode_gen.sv
`timescale 1ns/1ps
module test_sclk_mode_gen;
    localparam int STG    = 3;
    localparam int SETTLE = STG + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic int_sclk = 1'b1;
    logic cpol = 1'b0;
    logic cpha = 1'b0;
    logic sel_n = 1'b1;
    logic rd_n = 1'b1;
    logic bus_sclk;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    sclk_mode_gen #(.SYNC_STAGES(STG)) i_sclk_mode_gen (
        .clk(clk), .rst_n(rst_n), .int_sclk(int_sclk), .cpol(cpol),
        .cpha(cpha), .sel_n(sel_n), .rd_n(rd_n), .bus_sclk(bus_sclk)
    );

    task automatic check(input logic exp, input string tag);
        n_tests++;
        if (bus_sclk !== exp) begin
            n_fail++;
            $display("FAIL %s: bus_sclk=%0b expected %0b", tag, bus_sclk, exp);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic set_int(input logic v);
        @(negedge clk);
        int_sclk = v;
        settle();
    endtask

    task automatic read_pulse();
        @(negedge clk);
        sel_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        sel_n = 1'b1; rd_n = 1'b1;
        settle();
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(1'b0, "R1 during reset");
        rst_n = 1'b1;
        settle();
        check(1'b0, "R1 after release, clock high, not armed");
    endtask

    task automatic t_mode0();
        cpol = 1'b0; cpha = 1'b0;
        read_pulse();
        check(1'b0, "R2 dummy read idle low");
        set_int(1'b0);
        check(1'b0, "R3 low phase keeps idle");
        set_int(1'b1);
        check(1'b1, "R3 first rising edge passes");
        for (int b = 1; b < 8; b++) begin
            set_int(1'b0);
            check(1'b0, "R3 bit low phase");
            set_int(1'b1);
            check(1'b1, "R3 bit high phase");
        end
        repeat (4) @(negedge clk);
        check(1'b1, "R6 ends high after last bit");
        @(negedge clk); sel_n = 1'b0;
        settle();
        sel_n = 1'b1;
        settle();
        check(1'b1, "R2 select without read ignored");
        read_pulse();
        check(1'b0, "R6 read restores idle low");
    endtask

    task automatic t_mode2();
        cpol = 1'b1; cpha = 1'b0;
        settle();
        check(1'b1, "R7 mode 2 idle high");
        set_int(1'b0);
        check(1'b1, "R7 mode 2 low phase held");
        set_int(1'b1);
        check(1'b0, "R7 mode 2 inverted rising");
        read_pulse();
        check(1'b1, "R7 mode 2 idle after read");
    endtask

    task automatic t_mode3();
        cpol = 1'b1; cpha = 1'b1;
        set_int(1'b0);
        check(1'b0, "R5 mode 3 low after dummy write");
        set_int(1'b1);
        check(1'b1, "R5 mode 3 high");
        read_pulse();
        check(1'b1, "R5 read ignored in phase 1");
        set_int(1'b0);
        check(1'b0, "R5 passes low again");
        set_int(1'b1);
    endtask

    task automatic t_mode1();
        cpol = 1'b0; cpha = 1'b1;
        settle();
        check(1'b0, "R7 mode 1 idle low");
        set_int(1'b0);
        check(1'b1, "R7 mode 1 inverted");
        set_int(1'b1);
        check(1'b0, "R7 mode 1 back idle");
    endtask

    task automatic t_prio();
        cpol = 1'b0; cpha = 1'b0;
        read_pulse();
        @(negedge clk);
        sel_n = 1'b0; rd_n = 1'b0;
        int_sclk = 1'b0;
        settle();
        int_sclk = 1'b1;
        settle();
        check(1'b0, "R4 clear beats arm while strobe held");
        sel_n = 1'b1; rd_n = 1'b1;
        settle();
        check(1'b0, "R4 still idle after strobe release");
    endtask

    task automatic t_reg();
        cpol = 1'b0; cpha = 1'b1;
        set_int(1'b0);
        check(1'b1, "R8 settled inverted");
        @(negedge clk);
        cpol = 1'b1;
        #2;
        check(1'b1, "R8 no change before edge");
        @(negedge clk);
        check(1'b0, "R8 updates at edge");
        set_int(1'b1);
    endtask

    initial begin
        #(200000 * 20);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: timeout actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_mode0();
        t_mode2();
        t_mode3();
        t_mode1();
        t_prio();
        t_reg();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule